// File: doc/BRIEF.md
# Next-PC Selector with Signed Branch Resolution

This block is the combinational part of a single-cycle processor that picks the program counter for the next instruction. It takes the current word-addressed PC, the opcode of the instruction being executed, the two source register values, the immediate field and a halted flag. From these it produces the address to fetch next, an enable for the PC register, and the return address that a jump-and-link writes into its destination register. Register-file writes and data-memory access are handled elsewhere.

The PC normally steps by one word. An absolute jump loads the immediate, a register jump loads the first source operand, and four conditional branches compare the two operands as two's-complement numbers. A taken branch adds the immediate to the PC, treating the immediate as a signed 8-bit offset so that backward loops work. All PC arithmetic wraps modulo the address space. The halt opcode stops the PC, and once the surrounding core sets the halted flag, the PC stays frozen whatever opcode is presented.

Top module: `npc_unit`

## Requirements
- R1: For every opcode that is not halt (00000), j (10101), jal (10110), jr (10111) or a branch (11000 to 11011), including the unused codes 11100 to 11111, next_pc is pc+1 modulo 256 and pc_en is 1.
- R2: Opcode 11000 takes the branch exactly when rs_val is less than rt_val, both read as signed 8-bit values.
- R3: Opcode 11001 takes the branch exactly when rs_val is greater than or equal to rt_val, both read as signed 8-bit values.
- R4: Opcode 11010 takes the branch when rs_val equals rt_val, and opcode 11011 takes it when they differ.
- R5: A taken branch gives next_pc = pc + imm modulo 256, with imm read as signed 8-bit, so offsets 0x80 to 0xFF move the PC backward.
- R6: A branch that is not taken gives next_pc = pc+1 modulo 256 with pc_en at 1.
- R7: Opcode 10101 gives next_pc = imm.
- R8: Opcode 10111 gives next_pc = rs_val.
- R9: Opcode 10110 gives next_pc = imm, and link_pc carries pc+1 for the register write.
- R10: link_pc equals pc+1 modulo 256 for every input combination, so pc 0xFF yields 0x00.
- R11: Opcode 00000 drives pc_en to 0 and next_pc to the current pc.
- R12: While halted is 1, pc_en is 0 and next_pc equals pc for every opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc | input | 8 | Current program counter (word address) |
| opcode | input | 5 | Opcode of the instruction in execution |
| rs_val | input | 8 | Value of the first source register |
| rt_val | input | 8 | Value of the second source register |
| imm | input | 8 | Immediate field: jump target or signed branch offset |
| halted | input | 1 | Core has stopped; freezes the PC |
| next_pc | output | 8 | Address to load into the PC |
| pc_en | output | 1 | PC register load enable |
| link_pc | output | 8 | Return address pc+1 for jump-and-link |

## Verification
The hardest cases are the signed comparisons where an unsigned compare would give the opposite answer: operands on either side of the 0x7F/0x80 boundary, such as 0x7F against 0x80 or 0xFF against 0x01, and equal operands under less-than and greater-or-equal. The stimulus places these pairs directly under each branch opcode and combines them with PC values near 0x00 and 0xFF and offsets of 0x80 and 0xFF, so both wrap-around and backward targets appear. A long stream of random operand, opcode and flag combinations then follows, each compared against a behavioural model.

// File: rtl/npc_pkg.sv
package npc_pkg;
   localparam int OPC_W = 5;

   localparam logic [OPC_W-1:0] OPC_HALT  = 5'b00000;
   localparam logic [OPC_W-1:0] OPC_JABS  = 5'b10101;
   localparam logic [OPC_W-1:0] OPC_JLINK = 5'b10110;
   localparam logic [OPC_W-1:0] OPC_JREG  = 5'b10111;
   // Branches share the prefix 110; the two low bits pick the condition.
   localparam logic [2:0]       BR_PREFIX = 3'b110;

   typedef enum logic [1:0] {
      CND_LT = 2'b00,
      CND_GE = 2'b01,
      CND_EQ = 2'b10,
      CND_NE = 2'b11
   } cond_e;

   typedef enum logic [2:0] {
      FLOW_SEQ,
      FLOW_ABS,
      FLOW_REG,
      FLOW_REL,
      FLOW_HOLD
   } flow_e;
endpackage

// File: rtl/npc_cond.sv
module npc_cond #(
   parameter int  DATA_W     = 8,
   parameter bit  CMP_BY_SUB = 1'b1
) (
   input  logic [DATA_W-1:0] a_val,
   input  logic [DATA_W-1:0] b_val,
   input  npc_pkg::cond_e    cond,
   output logic              take
);
   import npc_pkg::*;

   if (DATA_W < 2) begin : g_bad_width
      $error("npc_cond: DATA_W must be at least 2");
   end

   logic lt_s;
   logic eq_v;

   generate
      if (CMP_BY_SUB) begin : g_sub
         // Sign-extend by one bit; the borrow-out sign gives signed less-than.
         logic [DATA_W:0] diff;
         assign diff = {a_val[DATA_W-1], a_val} - {b_val[DATA_W-1], b_val};
         assign lt_s = diff[DATA_W];
      end else begin : g_cmp
         assign lt_s = $signed(a_val) < $signed(b_val);
      end
   endgenerate

   assign eq_v = (a_val == b_val);

   always_comb begin
      unique case (cond)
         CND_LT:  take = lt_s;
         CND_GE:  take = ~lt_s;
         CND_EQ:  take = eq_v;
         default: take = ~eq_v;
      endcase
   end
endmodule

// File: rtl/npc_adders.sv
module npc_adders #(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] ofs,
   output logic [ADDR_W-1:0] pc_inc,
   output logic [ADDR_W-1:0] pc_rel
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   if (ADDR_W < 2) begin : g_bad_width
      $error("npc_adders: ADDR_W must be at least 2");
   end

   // Offset width equals PC width, so modular addition handles negative offsets.
   assign pc_inc = pc + ONE;
   assign pc_rel = pc + ofs;
endmodule

// File: rtl/npc_decode.sv
module npc_decode #(
   parameter int OPC_W = 5
) (
   input  logic [OPC_W-1:0] opcode,
   input  logic             halted,
   input  logic             take,
   output npc_pkg::flow_e   flow,
   output npc_pkg::cond_e   cond
);
   import npc_pkg::*;

   if (OPC_W != npc_pkg::OPC_W) begin : g_bad_opc
      $error("npc_decode: OPC_W must match the package opcode width");
   end

   logic is_branch;
   assign is_branch = (opcode[OPC_W-1 -: 3] == BR_PREFIX);
   assign cond      = cond_e'(opcode[1:0]);

   always_comb begin
      if (halted || opcode == OPC_HALT) begin
         flow = FLOW_HOLD;
      end else if (is_branch) begin
         flow = take ? FLOW_REL : FLOW_SEQ;
      end else begin
         unique case (opcode)
            OPC_JABS, OPC_JLINK: flow = FLOW_ABS;
            OPC_JREG:            flow = FLOW_REG;
            default:             flow = FLOW_SEQ;
         endcase
      end
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int OPC_W      = 5,
   parameter bit CMP_BY_SUB = 1'b1
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [DATA_W-1:0] rs_val,
   input  logic [DATA_W-1:0] rt_val,
   input  logic [ADDR_W-1:0] imm,
   input  logic              halted,
   output logic [ADDR_W-1:0] next_pc,
   output logic              pc_en,
   output logic [ADDR_W-1:0] link_pc
);
   import npc_pkg::*;

   if (DATA_W != ADDR_W) begin : g_bad_data
      $error("npc_unit: register-indirect jumps need DATA_W == ADDR_W");
   end

   logic [ADDR_W-1:0] pc_inc;
   logic [ADDR_W-1:0] pc_rel;
   logic              take;
   flow_e             flow;
   cond_e             cond;

   npc_adders #(.ADDR_W(ADDR_W)) u_add (
      .pc     (pc),
      .ofs    (imm),
      .pc_inc (pc_inc),
      .pc_rel (pc_rel)
   );

   npc_cond #(.DATA_W(DATA_W), .CMP_BY_SUB(CMP_BY_SUB)) u_cond (
      .a_val (rs_val),
      .b_val (rt_val),
      .cond  (cond),
      .take  (take)
   );

   npc_decode #(.OPC_W(OPC_W)) u_dec (
      .opcode (opcode),
      .halted (halted),
      .take   (take),
      .flow   (flow),
      .cond   (cond)
   );

   always_comb begin
      unique case (flow)
         FLOW_ABS:  next_pc = imm;
         FLOW_REG:  next_pc = rs_val;
         FLOW_REL:  next_pc = pc_rel;
         FLOW_HOLD: next_pc = pc;
         default:   next_pc = pc_inc;
      endcase
   end

   assign pc_en   = (flow != FLOW_HOLD);
   assign link_pc = pc_inc;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int OPC_W  = 5
) (
   input logic [ADDR_W-1:0] pc,
   input logic [OPC_W-1:0]  opcode,
   input logic [DATA_W-1:0] rs_val,
   input logic [DATA_W-1:0] rt_val,
   input logic [ADDR_W-1:0] imm,
   input logic              halted,
   input logic [ADDR_W-1:0] next_pc,
   input logic              pc_en,
   input logic [ADDR_W-1:0] link_pc
);
   logic known;
   assign known = !$isunknown({pc, opcode, rs_val, rt_val, imm, halted});

   always_comb begin
      if (known) begin
         // R10: link is one word past pc, wrapping
         a_r10_link_step: assert (ADDR_W'(link_pc - pc) == ADDR_W'(1));
         // R12: halted freezes the PC
         if (halted) begin
            a_r12_halted_freezes: assert (!pc_en && next_pc == pc);
         end
         // R11: halt opcode stops the PC
         if (opcode == 5'b00000) begin
            a_r11_hlt_holds: assert (!pc_en && next_pc == pc);
         end
         if (!halted && opcode == 5'b10101) begin
            a_r7_jump_abs: assert (pc_en && next_pc == imm);
         end
         if (!halted && opcode == 5'b10111) begin
            a_r8_jump_reg: assert (pc_en && next_pc == rs_val);
         end
         if (!halted && opcode == 5'b11000 && $signed(rs_val) >= $signed(rt_val)) begin
            a_r6_blt_fallthrough: assert (pc_en && next_pc == link_pc);
         end
         if (!halted && opcode == 5'b11010 && rs_val == rt_val) begin
            a_r5_beq_target: assert (ADDR_W'(next_pc - pc) == imm);
         end
      end
   end
endmodule

bind npc_unit npc_unit_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPC_W(OPC_W)
) u_npc_chk (
   .pc(pc), .opcode(opcode), .rs_val(rs_val), .rt_val(rt_val), .imm(imm),
   .halted(halted), .next_pc(next_pc), .pc_en(pc_en), .link_pc(link_pc)
);

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic [7:0] pc = '0, rs_val = '0, rt_val = '0, imm = '0;
   logic [4:0] opcode = '0;
   logic       halted = 1'b1;
   logic [7:0] next_pc, link_pc;
   logic       pc_en;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   npc_unit dut (
      .pc(pc), .opcode(opcode), .rs_val(rs_val), .rt_val(rt_val), .imm(imm),
      .halted(halted), .next_pc(next_pc), .pc_en(pc_en), .link_pc(link_pc)
   );

   function automatic string tag_of(logic [4:0] op, logic h);
      if (h)                        return "R12";
      if (op == 5'b00000)           return "R11";
      if (op == 5'b10101)           return "R7";
      if (op == 5'b10110)           return "R9";
      if (op == 5'b10111)           return "R8";
      if (op == 5'b11000)           return "R2/R5/R6";
      if (op == 5'b11001)           return "R3/R5/R6";
      if (op == 5'b11010 || op == 5'b11011) return "R4/R5/R6";
      return "R1";
   endfunction

   // Behavioural reference, written from the requirements.
   task automatic expect_vals(output int e_next, output int e_en, output int e_link);
      int p, s, t, off;
      bit tk;
      p = pc; s = rs_val; t = rt_val; off = imm;
      if (s > 127) s -= 256;
      if (t > 127) t -= 256;
      if (off > 127) off -= 256;
      e_link = (p + 1) % 256;
      e_en = 1;
      e_next = (p + 1) % 256;
      if (halted || opcode == 5'd0) begin
         e_en = 0; e_next = p;
      end else if (opcode == 5'b10101 || opcode == 5'b10110) begin
         e_next = imm;
      end else if (opcode == 5'b10111) begin
         e_next = rs_val;
      end else if (opcode >= 5'b11000 && opcode <= 5'b11011) begin
         case (opcode)
            5'b11000: tk = (s <  t);
            5'b11001: tk = (s >= t);
            5'b11010: tk = (s == t);
            default:  tk = (s != t);
         endcase
         if (tk) e_next = (p + off + 256) % 256;
      end
   endtask

   task automatic check_one(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: pc=%02h op=%05b rs=%02h rt=%02h imm=%02h halted=%0b actual=%0h expected=%0h",
                  tag_of(opcode, halted), what, pc, opcode, rs_val, rt_val, imm, halted, act, exp);
      end
   endtask

   task automatic apply(logic [7:0] p, logic [4:0] op, logic [7:0] s, logic [7:0] t,
                        logic [7:0] i, logic h);
      int e_next, e_en, e_link;
      @(posedge clk);
      #1;
      pc = p; opcode = op; rs_val = s; rt_val = t; imm = i; halted = h;
      @(negedge clk);
      expect_vals(e_next, e_en, e_link);
      check_one("next_pc", int'(next_pc), e_next);
      check_one("pc_en",   int'(pc_en),   e_en);
      check_one("link_pc", int'(link_pc), e_link);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R12: starting state with the core halted
      apply(8'h10, 5'b00100, 8'h00, 8'h00, 8'h00, 1'b1);
      // R1: ALU, memory and unused opcodes step by one
      apply(8'h10, 5'b00100, 8'h03, 8'h04, 8'h20, 1'b0);
      apply(8'h7F, 5'b10011, 8'h03, 8'h04, 8'h20, 1'b0);
      apply(8'h20, 5'b11100, 8'h00, 8'h00, 8'h40, 1'b0);
      apply(8'h20, 5'b11111, 8'h00, 8'h00, 8'h40, 1'b0);
      // R10: link wraps at the top of the space
      apply(8'hFF, 5'b00001, 8'h00, 8'h00, 8'h00, 1'b0);
      // R2: signed less-than across the sign boundary
      apply(8'h40, 5'b11000, 8'h80, 8'h7F, 8'h05, 1'b0); // -128 < 127: taken
      apply(8'h40, 5'b11000, 8'h7F, 8'h80, 8'h05, 1'b0); // not taken
      apply(8'h40, 5'b11000, 8'hFF, 8'h01, 8'h05, 1'b0); // -1 < 1: taken
      apply(8'h40, 5'b11000, 8'h33, 8'h33, 8'h05, 1'b0); // R6 equal: not taken
      // R3: signed greater-or-equal
      apply(8'h40, 5'b11001, 8'h33, 8'h33, 8'h06, 1'b0);
      apply(8'h40, 5'b11001, 8'h01, 8'hFF, 8'h06, 1'b0);
      apply(8'h40, 5'b11001, 8'h80, 8'h7F, 8'h06, 1'b0);
      // R4: equality and inequality
      apply(8'h50, 5'b11010, 8'hA5, 8'hA5, 8'h03, 1'b0);
      apply(8'h50, 5'b11010, 8'hA5, 8'hA4, 8'h03, 1'b0);
      apply(8'h50, 5'b11011, 8'hA5, 8'hA4, 8'h03, 1'b0);
      apply(8'h50, 5'b11011, 8'h00, 8'h00, 8'h03, 1'b0);
      // R5: backward offsets and wrap-around targets
      apply(8'h05, 5'b11010, 8'h00, 8'h00, 8'hFF, 1'b0);
      apply(8'h05, 5'b11010, 8'h00, 8'h00, 8'h80, 1'b0);
      apply(8'hF0, 5'b11011, 8'h01, 8'h00, 8'h7F, 1'b0);
      apply(8'hFF, 5'b11000, 8'h01, 8'h00, 8'h10, 1'b0); // R6 fall-through wraps
      // R7, R8, R9: jumps
      apply(8'h12, 5'b10101, 8'h99, 8'h00, 8'hC3, 1'b0);
      apply(8'h12, 5'b10111, 8'h99, 8'h00, 8'hC3, 1'b0);
      apply(8'hFF, 5'b10110, 8'h99, 8'h00, 8'h3C, 1'b0);
      // R11: halt opcode
      apply(8'h66, 5'b00000, 8'h11, 8'h22, 8'h33, 1'b0);
      // R12: halted flag overrides jumps and branches
      apply(8'h66, 5'b10101, 8'h11, 8'h22, 8'h33, 1'b1);
      apply(8'h66, 5'b11010, 8'h11, 8'h11, 8'h33, 1'b1);
      // Random mix, biased toward control opcodes and boundary operands
      for (int n = 0; n < 2000; n++) begin
         logic [4:0] op;
         logic [7:0] s, t;
         op = (n % 2 == 0) ? 5'(5'b10101 + ($urandom % 11)) : 5'($urandom);
         s  = 8'($urandom);
         t  = (n % 5 == 0) ? s : 8'($urandom);
         if (n % 7 == 0) begin s = 8'h80; t = 8'h7F; end
         apply(8'($urandom), op, s, t, 8'($urandom), ($urandom % 8) == 0);
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule